// File: doc/BRIEF.md
# LNS Product-Sum-Power Pipeline

This block is an arithmetic pipeline for numbers held in logarithmic form. Each cycle it can accept four operands a, b, c, d and a three-bit exponent selector. Five clock edges later it returns (a·b + c·d)^e, where e is one of +1, -1, +2, -2, +0.5 or -0.5. It has no stall path. A result comes out every cycle in which one was accepted five edges earlier.

Each operand word has three fields: a sign, a zero flag and a two's-complement base-2 logarithm with 6 integer and 8 fraction bits. Each product is formed by adding two logarithms. The two products are then combined with a correction term that is read from a table indexed by their log difference. The exponent is applied by shifting and negating the result logarithm. Two flags report results that cannot be represented: a negative base under a square root, and a zero base under a negative power.

Top module: `lns_psp_pipe`

## Requirements
- R1: Word layout: bit 15 is the sign, bit 14 is the zero flag and bits 13:0 hold the log L in two's complement with 8 fraction bits. The value is (-1)^sign·2^(L/256). When the zero flag is set the word is zero, whatever its other bits hold.
- R2: valid_o equals valid_i as sampled exactly five rising edges earlier. Back-to-back inputs produce back-to-back results, and inputs with valid_i low produce no result.
- R3: Each product takes the sum of its two operand logs and the XOR of its operand signs. If either operand is zero, that product is zero. If only one product is zero, the other product passes through unchanged.
- R4: With like signs and equal product logs, the base log is the product log plus 256, exactly. With a log difference of 2048 (8.0) or more, the base equals the larger product exactly. This holds for like and unlike signs.
- R5: With like signs, the base log is within 40 LSB of log2 of the exact sum.
- R6: With unlike signs, the base takes the sign of the larger-magnitude product. For a log difference of at least 512, its log is within 40 LSB of exact.
- R7: Two products of equal log and opposite sign give a zero base.
- R8: Selector bits 1:0 pick the magnitude of e: 00 gives 1, 01 gives 2, 10 gives 0.5, and 11 acts as 1. Selector bit 2 makes e negative. A magnitude of 2 shifts the log left by one. A magnitude of 0.5 shifts it arithmetically right by one, rounding toward minus infinity. Negation is applied after the shift.
- R9: For |e| = 2 the result sign is 0. For |e| = 1 it is the base sign. For |e| = 0.5 it is 0, and invalid_o is set when the base is negative.
- R10: A zero base with positive e gives a zero result (sign 0, log 0). With negative e it sets dz_o and returns zero flag 0, sign 0 and log 8191.
- R11: The final log saturates to the range [-8192, 8191].
- R12: While rst_ni is low (asynchronously), valid_o, res_o, invalid_o and dz_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Operand set present |
| a_i | input | 16 | Operand a |
| b_i | input | 16 | Operand b |
| c_i | input | 16 | Operand c |
| d_i | input | 16 | Operand d |
| exp_sel_i | input | 3 | Exponent selector |
| valid_o | output | 1 | Result present |
| res_o | output | 16 | Result word |
| invalid_o | output | 1 | Negative base under a square root |
| dz_o | output | 1 | Zero base under a negative power |

## Verification
The bench streams operand sets back to back with a one-cycle bubble, so that latency and bubble handling are both seen at the ports.

Each kind of product pair tests a different path:
- Equal logs with like signs, and differences of 8.0 or more, test the exact paths.
- Mid-range differences with like and with unlike signs test the two correction tables against a real-valued model.
- Opposite-sign pairs of equal log test cancellation.
- Zero operands that carry stray sign and log bits test the zero path.

The same bases are run through every selector code to separate the shift, negation, sign and flag rules. Extreme logs drive both saturation limits.

// File: rtl/lns_psp_pkg.sv
package lns_psp_pkg;
  typedef enum logic [1:0] {
    MAG_ONE  = 2'b00,
    MAG_TWO  = 2'b01,
    MAG_HALF = 2'b10,
    MAG_RSV  = 2'b11
  } exp_mag_e;
endpackage

// File: rtl/lns_prod.sv
module lns_prod #(
  parameter int LW = 14
) (
  input  logic                 sa_i,
  input  logic                 za_i,
  input  logic signed [LW-1:0] la_i,
  input  logic                 sb_i,
  input  logic                 zb_i,
  input  logic signed [LW-1:0] lb_i,
  output logic                 s_o,
  output logic                 z_o,
  output logic signed [LW:0]   l_o
);
  always_comb begin
    z_o = za_i | zb_i;
    s_o = z_o ? 1'b0 : (sa_i ^ sb_i);
    l_o = z_o ? '0 : ($signed({la_i[LW-1], la_i}) + $signed({lb_i[LW-1], lb_i}));
  end
endmodule

// File: rtl/lns_align.sv
module lns_align #(
  parameter int PW = 15
) (
  input  logic                 xs_i,
  input  logic                 xz_i,
  input  logic signed [PW-1:0] xl_i,
  input  logic                 ys_i,
  input  logic                 yz_i,
  input  logic signed [PW-1:0] yl_i,
  output logic signed [PW-1:0] mx_o,
  output logic        [PW:0]   diff_o,
  output logic                 like_o,
  output logic                 pass_o,
  output logic                 s_o,
  output logic                 z_o
);
  logic signed [PW:0] dxy;
  logic               x_ge;

  always_comb begin
    dxy    = $signed({xl_i[PW-1], xl_i}) - $signed({yl_i[PW-1], yl_i});
    x_ge   = ~dxy[PW];
    mx_o   = '0;
    diff_o = '0;
    like_o = 1'b0;
    pass_o = 1'b0;
    s_o    = 1'b0;
    z_o    = 1'b0;
    if (xz_i && yz_i) begin
      z_o = 1'b1;
    end else if (yz_i) begin
      mx_o = xl_i; s_o = xs_i; pass_o = 1'b1;
    end else if (xz_i) begin
      mx_o = yl_i; s_o = ys_i; pass_o = 1'b1;
    end else begin
      like_o = (xs_i == ys_i);
      mx_o   = x_ge ? xl_i : yl_i;
      diff_o = x_ge ? dxy : -dxy;
      s_o    = x_ge ? xs_i : ys_i;
      if (!like_o && dxy == '0) begin
        // exact cancellation
        z_o = 1'b1; s_o = 1'b0; mx_o = '0;
      end
    end
  end
endmodule

// File: rtl/lns_corr.sv
module lns_corr #(
  parameter int PW   = 15,
  parameter int FRAC = 8
) (
  input  logic signed [PW-1:0] mx_i,
  input  logic        [PW:0]   diff_i,
  input  logic                 like_i,
  input  logic                 pass_i,
  input  logic                 s_i,
  input  logic                 z_i,
  output logic                 s_o,
  output logic                 z_o,
  output logic signed [PW:0]   l_o
);
  localparam int STEP_SH = FRAC - 2;
  localparam int LIM     = 8 << FRAC;
  localparam int CW      = 12;

  if (FRAC != 8) begin : g_frac_chk
    $error("lns_corr tables are scaled for 8 fraction bits");
  end

  // log2(1+2^-d) in 1/256 units, d = idx/4
  function automatic logic signed [CW-1:0] f_add(input logic [4:0] idx);
    case (idx)
      5'd0:  f_add = 12'sd256; 5'd1:  f_add = 12'sd225; 5'd2:  f_add = 12'sd198; 5'd3:  f_add = 12'sd172;
      5'd4:  f_add = 12'sd150; 5'd5:  f_add = 12'sd130; 5'd6:  f_add = 12'sd112; 5'd7:  f_add = 12'sd96;
      5'd8:  f_add = 12'sd82;  5'd9:  f_add = 12'sd70;  5'd10: f_add = 12'sd60;  5'd11: f_add = 12'sd51;
      5'd12: f_add = 12'sd44;  5'd13: f_add = 12'sd37;  5'd14: f_add = 12'sd31;  5'd15: f_add = 12'sd26;
      5'd16: f_add = 12'sd22;  5'd17: f_add = 12'sd19;  5'd18: f_add = 12'sd16;  5'd19: f_add = 12'sd13;
      5'd20: f_add = 12'sd11;  5'd21: f_add = 12'sd10;  5'd22: f_add = 12'sd8;   5'd23: f_add = 12'sd7;
      5'd24: f_add = 12'sd6;   5'd25: f_add = 12'sd5;   5'd26: f_add = 12'sd4;   5'd27: f_add = 12'sd3;
      5'd28: f_add = 12'sd3;   5'd29: f_add = 12'sd2;   5'd30: f_add = 12'sd2;   default: f_add = 12'sd2;
    endcase
  endfunction

  // log2(1-2^-d); entry 0 sampled at d=1/8
  function automatic logic signed [CW-1:0] f_sub(input logic [4:0] idx);
    case (idx)
      5'd0:  f_sub = -12'sd919; 5'd1:  f_sub = -12'sd679; 5'd2:  f_sub = -12'sd454; 5'd3:  f_sub = -12'sd333;
      5'd4:  f_sub = -12'sd256; 5'd5:  f_sub = -12'sd201; 5'd6:  f_sub = -12'sd161; 5'd7:  f_sub = -12'sd130;
      5'd8:  f_sub = -12'sd106; 5'd9:  f_sub = -12'sd87;  5'd10: f_sub = -12'sd72;  5'd11: f_sub = -12'sd59;
      5'd12: f_sub = -12'sd49;  5'd13: f_sub = -12'sd41;  5'd14: f_sub = -12'sd34;  5'd15: f_sub = -12'sd29;
      5'd16: f_sub = -12'sd24;  5'd17: f_sub = -12'sd20;  5'd18: f_sub = -12'sd17;  5'd19: f_sub = -12'sd14;
      5'd20: f_sub = -12'sd12;  5'd21: f_sub = -12'sd10;  5'd22: f_sub = -12'sd8;   5'd23: f_sub = -12'sd7;
      5'd24: f_sub = -12'sd6;   5'd25: f_sub = -12'sd5;   5'd26: f_sub = -12'sd4;   5'd27: f_sub = -12'sd3;
      5'd28: f_sub = -12'sd3;   5'd29: f_sub = -12'sd2;   5'd30: f_sub = -12'sd2;   default: f_sub = -12'sd2;
    endcase
  endfunction

  logic [4:0]             idx;
  logic                   in_rng;
  logic signed [CW-1:0]   corr;

  always_comb begin
    idx    = diff_i[STEP_SH+4:STEP_SH];
    in_rng = (diff_i < (PW+1)'(LIM));
    if (pass_i || z_i || !in_rng) corr = '0;
    else if (like_i)              corr = f_add(idx);
    else                          corr = f_sub(idx);
    s_o = s_i;
    z_o = z_i;
    l_o = $signed({mx_i[PW-1], mx_i}) + $signed({{(PW+1-CW){corr[CW-1]}}, corr});
  end

  always_comb begin
    if (!pass_i && !z_i && like_i)
      a_r5_add_corr_range: assert (corr >= 0 && corr <= 12'sd256);
  end
endmodule

// File: rtl/lns_pow.sv
module lns_pow
  import lns_psp_pkg::*;
#(
  parameter int SW = 16,
  parameter int LW = 14
) (
  input  logic                 s_i,
  input  logic                 z_i,
  input  logic signed [SW-1:0] l_i,
  input  logic [2:0]           sel_i,
  output logic                 s_o,
  output logic                 z_o,
  output logic        [LW-1:0] l_o,
  output logic                 inv_o,
  output logic                 dz_o
);
  localparam int XW = SW + 2;
  localparam logic signed [XW-1:0] MAXV = XW'(2**(LW-1) - 1);
  localparam logic signed [XW-1:0] MINV = -(XW'(2**(LW-1)));

  exp_mag_e               mag;
  logic                   neg;
  logic signed [XW-1:0]   ext, sc, sat;

  always_comb begin
    mag = exp_mag_e'(sel_i[1:0]);
    neg = sel_i[2];
    ext = $signed({{2{l_i[SW-1]}}, l_i});
    case (mag)
      MAG_TWO:  sc = ext <<< 1;
      MAG_HALF: sc = ext >>> 1;
      default:  sc = ext;
    endcase
    if (neg) sc = -sc;
    if (sc > MAXV)      sat = MAXV;
    else if (sc < MINV) sat = MINV;
    else                sat = sc;

    s_o = 1'b0; z_o = 1'b0; l_o = '0; inv_o = 1'b0; dz_o = 1'b0;
    if (z_i) begin
      if (neg) begin
        dz_o = 1'b1;
        l_o  = MAXV[LW-1:0];
      end else begin
        z_o = 1'b1;
      end
    end else begin
      l_o   = sat[LW-1:0];
      s_o   = (mag == MAG_ONE || mag == MAG_RSV) ? s_i : 1'b0;
      inv_o = (mag == MAG_HALF) && s_i;
    end
  end

  always_comb begin
    if (mag == MAG_TWO) a_r9_square_pos: assert (!s_o);
    if (dz_o)           a_r10_dz_not_zero: assert (!z_o && !inv_o);
  end
endmodule

// File: rtl/lns_psp_pipe.sv
module lns_psp_pipe #(
  parameter int LOG_INT  = 6,
  parameter int LOG_FRAC = 8
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               valid_i,
  input  logic [LOG_INT+LOG_FRAC+1:0]        a_i,
  input  logic [LOG_INT+LOG_FRAC+1:0]        b_i,
  input  logic [LOG_INT+LOG_FRAC+1:0]        c_i,
  input  logic [LOG_INT+LOG_FRAC+1:0]        d_i,
  input  logic [2:0]                         exp_sel_i,
  output logic                               valid_o,
  output logic [LOG_INT+LOG_FRAC+1:0]        res_o,
  output logic                               invalid_o,
  output logic                               dz_o
);
  localparam int LW = LOG_INT + LOG_FRAC;
  localparam int WW = LW + 2;
  localparam int PW = LW + 1;
  localparam int SW = PW + 1;
  localparam int NP = 2;

  // stage 1: operand capture
  logic                   v1;
  logic [3:0][WW-1:0]     op1;
  logic [2:0]             sel1;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1 <= 1'b0; op1 <= '0; sel1 <= '0;
    end else begin
      v1 <= valid_i; op1 <= {d_i, c_i, b_i, a_i}; sel1 <= exp_sel_i;
    end
  end

  // stage 2: products
  logic [NP-1:0]          ps_c, pz_c;
  logic [NP-1:0][PW-1:0]  pl_c;
  for (genvar i = 0; i < NP; i++) begin : g_prod
    lns_prod #(.LW(LW)) u_prod (
      .sa_i (op1[2*i][WW-1]),   .za_i (op1[2*i][WW-2]),   .la_i (op1[2*i][LW-1:0]),
      .sb_i (op1[2*i+1][WW-1]), .zb_i (op1[2*i+1][WW-2]), .lb_i (op1[2*i+1][LW-1:0]),
      .s_o  (ps_c[i]),          .z_o  (pz_c[i]),          .l_o  (pl_c[i])
    );
  end

  logic                   v2;
  logic [NP-1:0]          ps2, pz2;
  logic [NP-1:0][PW-1:0]  pl2;
  logic [2:0]             sel2;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v2 <= 1'b0; ps2 <= '0; pz2 <= '0; pl2 <= '0; sel2 <= '0;
    end else begin
      v2 <= v1; ps2 <= ps_c; pz2 <= pz_c; pl2 <= pl_c; sel2 <= sel1;
    end
  end

  // stage 3: ordering and difference
  logic signed [PW-1:0] mx_c;
  logic        [PW:0]   diff_c;
  logic                 like_c, pass_c, as_c, az_c;
  lns_align #(.PW(PW)) u_align (
    .xs_i (ps2[0]), .xz_i (pz2[0]), .xl_i (pl2[0]),
    .ys_i (ps2[1]), .yz_i (pz2[1]), .yl_i (pl2[1]),
    .mx_o (mx_c), .diff_o (diff_c), .like_o (like_c), .pass_o (pass_c),
    .s_o  (as_c), .z_o (az_c)
  );

  logic                 v3, like3, pass3, s3, z3;
  logic signed [PW-1:0] mx3;
  logic        [PW:0]   diff3;
  logic [2:0]           sel3;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v3 <= 1'b0; like3 <= 1'b0; pass3 <= 1'b0; s3 <= 1'b0; z3 <= 1'b0;
      mx3 <= '0; diff3 <= '0; sel3 <= '0;
    end else begin
      v3 <= v2; like3 <= like_c; pass3 <= pass_c; s3 <= as_c; z3 <= az_c;
      mx3 <= mx_c; diff3 <= diff_c; sel3 <= sel2;
    end
  end

  // stage 4: Gaussian-log correction
  logic                 bs_c, bz_c;
  logic signed [SW-1:0] bl_c;
  lns_corr #(.PW(PW), .FRAC(LOG_FRAC)) u_corr (
    .mx_i (mx3), .diff_i (diff3), .like_i (like3), .pass_i (pass3),
    .s_i  (s3),  .z_i (z3),
    .s_o  (bs_c), .z_o (bz_c), .l_o (bl_c)
  );

  logic                 v4, s4, z4;
  logic signed [SW-1:0] l4;
  logic [2:0]           sel4;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v4 <= 1'b0; s4 <= 1'b0; z4 <= 1'b0; l4 <= '0; sel4 <= '0;
    end else begin
      v4 <= v3; s4 <= bs_c; z4 <= bz_c; l4 <= bl_c; sel4 <= sel3;
    end
  end

  // stage 5: power and output
  logic          rs_c, rz_c, inv_c, dz_c;
  logic [LW-1:0] rl_c;
  lns_pow #(.SW(SW), .LW(LW)) u_pow (
    .s_i (s4), .z_i (z4), .l_i (l4), .sel_i (sel4),
    .s_o (rs_c), .z_o (rz_c), .l_o (rl_c), .inv_o (inv_c), .dz_o (dz_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0; res_o <= '0; invalid_o <= 1'b0; dz_o <= 1'b0;
    end else begin
      valid_o <= v4; res_o <= {rs_c, rz_c, rl_c}; invalid_o <= inv_c; dz_o <= dz_c;
    end
  end

  // edges since reset, for the latency check
  logic [2:0] warm_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              warm_q <= '0;
    else if (warm_q != 3'd5)  warm_q <= warm_q + 3'd1;
  end

  a_r2_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q == 3'd5) |-> (valid_o == $past(valid_i, 5)));

  a_r7_zero_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && res_o[WW-2]) |-> (res_o[LW-1:0] == '0 && !res_o[WW-1]));

  a_r10_flags_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !(invalid_o && dz_o));
endmodule

// File: tb/sim_lns_psp_pipe.sv
`timescale 1ns/1ps
module sim_lns_psp_pipe;
  typedef struct packed {
    logic [15:0] a, b, c, d;
    logic [2:0]  sel;
    logic [7:0]  tol;
    logic        inv, dz, zr;
  } vec_t;

  function automatic logic [15:0] W(input bit s, input bit z, input int l);
    return {s, z, l[13:0]};
  endfunction

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{W(0,0,256), W(0,0,128), W(0,0,300), W(0,0,-100), 3'b000, 8'd40, 1'b0, 1'b0, 1'b0},
    '{W(0,0,200), W(0,0,56),  W(0,0,100), W(0,0,156),  3'b000, 8'd0,  1'b0, 1'b0, 1'b0},
    '{W(0,0,800), W(0,0,0),   W(1,0,100), W(0,0,100),  3'b000, 8'd40, 1'b0, 1'b0, 1'b0},
    '{W(0,0,0),   W(0,0,-300),W(1,0,500), W(0,0,400),  3'b000, 8'd40, 1'b0, 1'b0, 1'b0},
    '{W(1,0,300), W(0,0,10),  W(0,0,150), W(0,0,160),  3'b000, 8'd0,  1'b0, 1'b0, 1'b1},
    '{W(1,0,256), W(0,0,0),   W(1,0,0),   W(0,0,0),    3'b001, 8'd80, 1'b0, 1'b0, 1'b0},
    '{W(0,0,800), W(0,0,0),   W(1,0,100), W(0,0,100),  3'b100, 8'd40, 1'b0, 1'b0, 1'b0},
    '{W(0,0,0),   W(0,0,-300),W(1,0,500), W(0,0,400),  3'b010, 8'd40, 1'b1, 1'b0, 1'b0},
    '{W(0,0,256), W(0,0,128), W(0,0,300), W(0,0,-100), 3'b110, 8'd40, 1'b0, 1'b0, 1'b0},
    '{W(0,0,200), W(0,0,56),  W(0,0,100), W(0,0,156),  3'b101, 8'd0,  1'b0, 1'b0, 1'b0},
    '{W(0,0,100), W(1,1,500), W(0,0,50),  W(0,0,70),   3'b000, 8'd0,  1'b0, 1'b0, 1'b0},
    '{W(0,1,0),   W(0,0,5),   W(0,1,0),   W(0,0,9),    3'b100, 8'd0,  1'b0, 1'b1, 1'b0},
    '{W(0,1,0),   W(0,0,5),   W(0,0,7),   W(0,1,0),    3'b001, 8'd0,  1'b0, 1'b0, 1'b1},
    '{W(0,0,800), W(0,0,0),   W(1,0,100), W(0,0,100),  3'b011, 8'd40, 1'b0, 1'b0, 1'b0},
    '{W(0,0,8000),W(0,0,8000),W(0,0,0),   W(0,1,0),    3'b001, 8'd0,  1'b0, 1'b0, 1'b0},
    '{W(0,0,-8000),W(0,0,-8000),W(0,0,0), W(0,1,0),    3'b000, 8'd0,  1'b0, 1'b0, 1'b0},
    '{W(0,0,3000),W(0,0,0),   W(0,0,0),   W(0,0,100),  3'b000, 8'd0,  1'b0, 1'b0, 1'b0},
    '{W(0,0,3000),W(0,0,0),   W(1,0,0),   W(0,0,100),  3'b000, 8'd0,  1'b0, 1'b0, 1'b0}
  };

  function automatic string vreq(input int i);
    case (i)
      0: return "R5";     1: return "R4";  2: return "R6";  3: return "R6";
      4: return "R7";     5: return "R9";  6: return "R8";  7: return "R9";
      8: return "R8";     9: return "R8"; 10: return "R3 R1"; 11: return "R10";
      12: return "R10";  13: return "R8"; 14: return "R11"; 15: return "R11";
      16: return "R4";   default: return "R6";
    endcase
  endfunction

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        valid_i;
  logic [15:0] a_i, b_i, c_i, d_i;
  logic [2:0]  exp_sel_i;
  logic        valid_o;
  logic [15:0] res_o;
  logic        invalid_o, dz_o;

  lns_psp_pipe u0 (
    .clk_i, .rst_ni, .valid_i, .a_i, .b_i, .c_i, .d_i, .exp_sel_i,
    .valid_o, .res_o, .invalid_o, .dz_o
  );

  always #2 clk_i = ~clk_i;

  int n_chk = 0, n_err = 0, cyc = 0, oi = 0;
  int drv_cyc [NV];
  bit hold_chk = 1'b0;

  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic real wval(input logic [15:0] w);
    real r;
    if (w[14]) return 0.0;
    r = $pow(2.0, $itor($signed(w[13:0])) / 256.0);
    return w[15] ? -r : r;
  endfunction

  task automatic check_vec(input int i);
    vec_t  v;
    string rq;
    real   s, lg, em;
    int    act, exp, dlt;
    bit    esg;
    v   = VECS[i];
    rq  = vreq(i);
    act = $signed(res_o[13:0]);
    chk(cyc == drv_cyc[i] + 5, "R2", "latency", cyc - drv_cyc[i], 5);
    chk(res_o[14] == v.zr, rq, "zero flag", res_o[14], v.zr);
    chk(invalid_o == v.inv, rq, "invalid flag", invalid_o, v.inv);
    chk(dz_o == v.dz, rq, "dz flag", dz_o, v.dz);
    if (v.zr) begin
      chk(act == 0 && !res_o[15], rq, "zero word log", act, 0);
    end else if (v.dz) begin
      chk(act == 8191 && !res_o[15], rq, "dz word log", act, 8191);
    end else begin
      s  = wval(v.a) * wval(v.b) + wval(v.c) * wval(v.d);
      lg = $ln(s < 0.0 ? -s : s) / $ln(2.0) * 256.0;
      case (v.sel[1:0])
        2'b01:   em = 2.0;
        2'b10:   em = 0.5;
        default: em = 1.0;
      endcase
      if (v.sel[2]) em = -em;
      lg = lg * em;
      if (lg > 8191.0)  lg = 8191.0;
      if (lg < -8192.0) lg = -8192.0;
      exp = int'(lg);
      dlt = act - exp;
      if (dlt < 0) dlt = -dlt;
      chk(dlt <= int'(v.tol), rq, "log", act, exp);
      esg = (v.sel[1:0] == 2'b00 || v.sel[1:0] == 2'b11) ? (s < 0.0) : 1'b0;
      chk(res_o[15] == esg, rq, "sign", res_o[15], esg);
    end
  endtask

  initial begin
    forever begin
      @(negedge clk_i);
      if (rst_ni === 1'b1 && valid_o && !hold_chk) begin
        if (oi >= NV) chk(1'b0, "R2", "unexpected valid_o", 1, 0);
        else begin
          check_vec(oi);
          oi++;
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    chk(1'b0, "R2", "watchdog expired", cyc, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int extra;
    rst_ni = 1'b0; valid_i = 1'b0; exp_sel_i = '0;
    a_i = '0; b_i = '0; c_i = '0; d_i = '0;
    repeat (3) @(negedge clk_i);
    // R12: reset state
    chk(valid_o == 1'b0, "R12", "valid_o in reset", valid_o, 0);
    chk(res_o == '0, "R12", "res_o in reset", res_o, 0);
    chk(!invalid_o && !dz_o, "R12", "flags in reset", {invalid_o, dz_o}, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    for (int i = 0; i < NV; i++) begin
      if (i == 9) begin
        // bubble with stray data: must not produce a result (R2)
        valid_i = 1'b0; a_i = W(1,0,77); b_i = W(0,0,33); exp_sel_i = 3'b101;
        @(negedge clk_i);
      end
      valid_i = 1'b1;
      a_i = VECS[i].a; b_i = VECS[i].b; c_i = VECS[i].c; d_i = VECS[i].d;
      exp_sel_i = VECS[i].sel;
      drv_cyc[i] = cyc;
      @(negedge clk_i);
    end
    valid_i = 1'b0; a_i = W(0,0,1234);
    repeat (12) @(negedge clk_i);
    chk(oi == NV, "R2", "result count", oi, NV);

    // R12: asynchronous reset with a result at the output
    hold_chk = 1'b1;
    valid_i = 1'b1; a_i = W(0,0,10); b_i = W(0,0,20); c_i = W(0,0,30); d_i = W(0,0,40);
    exp_sel_i = 3'b000;
    @(negedge clk_i);
    valid_i = 1'b0;
    repeat (4) @(negedge clk_i);
    chk(valid_o == 1'b1, "R2", "valid_o before reset", valid_o, 1);
    rst_ni = 1'b0;
    #1;
    chk(valid_o == 1'b0 && res_o == '0, "R12", "outputs after async reset", res_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    extra = 0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk_i);
      if (valid_o) extra++;
    end
    chk(extra == 0, "R12", "results after reset", extra, 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule